// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block chooses a sampling-clock delay tap after a calibration sweep. The sweep visits every one of the N taps twice, so each result vector holds 2N bits and bit i belongs to tap i mod N. Two vectors arrive together with a start strobe. The first records whether a probe transfer succeeded. The second records whether the sampled data agreed with the reference. The block first folds the doubled sweep, so that a tap stays usable only when both of its visits succeeded. It then walks the folded vector one bit per clock and tracks the longest unbroken run of usable taps.

If the probe vector passed at every position, the probe result does not tell the taps apart. In that case the block uses the longest run of the folded data-match vector instead. The chosen tap is the midpoint of the winning run, wrapped back into the range 0..N-1. A one-cycle completion pulse carries either a valid flag together with the tap, or an error flag.

Top module: `tap_window_picker`

## Requirements
- R1: After reset, `done`, `sel_valid`, `sel_error` and `busy` are low and `tap_out` is 0.
- R2: Folding works on each vector separately. Tap t (t < N) stays set at bit positions t and t+N only when the input has both bit t and bit t+N set; otherwise both positions are cleared.
- R3: Input bits at position 2N and above have no effect on the result.
- R4: A run is a stretch of consecutive set bits in the folded vector, scanned from bit 0 upward. A later run replaces the best run only when it is strictly longer, so among runs of equal length the one with the lowest start wins.
- R5: A run that is still open at bit 2N-1 is closed and competes like any other run.
- R6: When the longest probe run is shorter than 2N, selection succeeds only if that run is at least 3 bits long. The tap is then ((start+end)/2) mod N, using truncating division.
- R7: When the longest probe run equals 2N, the same search runs on the folded data-match vector. Selection succeeds only if that run is non-empty, and the tap is its midpoint, computed as in R6.
- R8: When selection fails, `sel_error` is high with `done`, `sel_valid` is low, and `tap_out` is 0.
- R9: Exactly 2N+2 clock edges after the edge that accepts `start`, `done` is high for one cycle with exactly one of `sel_valid` and `sel_error`. Neither flag is high without `done`.
- R10: `busy` is high from the cycle after `start` is accepted until `done`. A `start` during that time is ignored and does not change the pending result.
- R11: A `num_taps` value above 16 behaves as 16. `num_taps` = 0 gives an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection; sampled while idle |
| num_taps | input | 5 | Tap count N, sampled with start |
| pass_vec | input | 32 | Probe pass results, bit i = visit i |
| match_vec | input | 32 | Data-compare match results, bit i = visit i |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle completion pulse |
| sel_valid | output | 1 | Selection succeeded (with done) |
| sel_error | output | 1 | Selection failed (with done) |
| tap_out | output | 4 | Selected tap, held until the next completion |

## Verification
The assertions assume that `num_taps`, `pass_vec` and `match_vec` matter only in the cycle in which `start` is accepted. They also assume that the tap index stays below the captured N, because only values below 16 reach the datapath. The stimulus drives new inputs only on falling edges. It keeps each start pulse one cycle long, except for one deliberate pulse during a busy scan. It uses tap counts from 0 to 20, so the clamp and the empty case are covered. The expected results come from a loop model in the bench that follows the requirements bit by bit.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_FINISH = 2'd2
  } tapsel_state_e;
endpackage

// File: rtl/tapsel_fold.sv
// Folds a doubled sweep: tap t survives only if both visits (t, t+N) are set.
module tapsel_fold #(
  parameter int MAX_TAPS = 16,
  localparam int VEC_W = 2 * MAX_TAPS,
  localparam int NUM_W = $clog2(MAX_TAPS + 1)
) (
  input  logic [NUM_W-1:0] n,
  input  logic [VEC_W-1:0] raw,
  output logic [VEC_W-1:0] folded
);
  logic [MAX_TAPS-1:0] second_visit;
  logic [MAX_TAPS-1:0] good;
  logic [VEC_W-1:0]    low_ext;

  assign second_visit = MAX_TAPS'(raw >> n);

  for (genvar t = 0; t < MAX_TAPS; t++) begin : g_tap
    assign good[t] = (NUM_W'(t) < n) & raw[t] & second_visit[t];
  end

  assign low_ext = VEC_W'(good);
  assign folded  = low_ext | (low_ext << n);
endmodule

// File: rtl/tapsel_run_track.sv
// Bit-serial longest-run tracker; a zero bit closes the open run.
module tapsel_run_track #(
  parameter int VEC_W = 32,
  localparam int LEN_W = $clog2(VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             bit_in,
  input  logic [LEN_W-1:0] idx,
  output logic [LEN_W-1:0] best_len,
  output logic [LEN_W-1:0] best_start,
  output logic [LEN_W-1:0] best_end
);
  logic [LEN_W-1:0] cur_len;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cur_len    <= '0;
      best_len   <= '0;
      best_start <= '0;
      best_end   <= '0;
    end else if (step) begin
      if (bit_in) begin
        cur_len <= cur_len + LEN_W'(1);
      end else begin
        if (cur_len > best_len) begin
          best_len   <= cur_len;
          best_start <= idx - cur_len;
          best_end   <= idx - LEN_W'(1);
        end
        cur_len <= '0;
      end
    end
  end

  // R4: the recorded window always spans exactly the recorded length
  p_run_span_r4: assert property (@(posedge clk) disable iff (rst)
    (best_len != '0) |-> ((best_end - best_start + LEN_W'(1)) == best_len));

  // R5: an open run never exceeds the bits scanned so far
  p_open_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
    step |-> (cur_len <= idx));
endmodule

// File: rtl/tap_window_picker.sv
module tap_window_picker
  import tapsel_pkg::*;
#(
  parameter int MAX_TAPS = 16,
  parameter int MIN_RUN  = 3,
  localparam int VEC_W = 2 * MAX_TAPS,
  localparam int NUM_W = $clog2(MAX_TAPS + 1),
  localparam int TAP_W = $clog2(MAX_TAPS),
  localparam int LEN_W = $clog2(VEC_W + 1),
  localparam int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num_taps,
  input  logic [VEC_W-1:0] pass_vec,
  input  logic [VEC_W-1:0] match_vec,
  output logic             busy,
  output logic             done,
  output logic             sel_valid,
  output logic             sel_error,
  output logic [TAP_W-1:0] tap_out
);
  tapsel_state_e    state;
  logic [NUM_W-1:0] n_clamp, n_q;
  logic [LEN_W-1:0] idx, last_idx;
  logic             accept;

  logic [VEC_W-1:0] raw_lane    [LANES];
  logic [VEC_W-1:0] folded_lane [LANES];
  logic [VEC_W-1:0] shift_lane  [LANES];
  logic [LEN_W-1:0] run_len     [LANES];
  logic [LEN_W-1:0] run_start   [LANES];
  logic [LEN_W-1:0] run_end     [LANES];

  assign n_clamp  = (num_taps > NUM_W'(MAX_TAPS)) ? NUM_W'(MAX_TAPS) : num_taps;
  assign accept   = (state == ST_IDLE) && start;
  assign last_idx = LEN_W'(n_q) << 1;
  assign busy     = (state != ST_IDLE);

  assign raw_lane[0] = pass_vec;
  assign raw_lane[1] = match_vec;

  // Lane 0 = probe pass, lane 1 = data match; both scanned in parallel
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tapsel_fold #(.MAX_TAPS(MAX_TAPS)) u_fold (
      .n      (n_clamp),
      .raw    (raw_lane[k]),
      .folded (folded_lane[k])
    );

    tapsel_run_track #(.VEC_W(VEC_W)) u_track (
      .clk        (clk),
      .rst        (rst),
      .clear      (accept),
      .step       (state == ST_SCAN),
      .bit_in     (shift_lane[k][0]),
      .idx        (idx),
      .best_len   (run_len[k]),
      .best_start (run_start[k]),
      .best_end   (run_end[k])
    );
  end

  // Selection decision
  logic             all_pass, sel_ok;
  logic [LEN_W-1:0] win_start, win_end, mid, wrapped;
  logic [LEN_W:0]   span_sum;

  always_comb begin
    all_pass  = (run_len[0] == last_idx);
    sel_ok    = all_pass ? (run_len[1] != '0) : (run_len[0] >= LEN_W'(MIN_RUN));
    win_start = all_pass ? run_start[1] : run_start[0];
    win_end   = all_pass ? run_end[1]   : run_end[0];
    span_sum  = {1'b0, win_start} + {1'b0, win_end};
    mid       = LEN_W'(span_sum >> 1);
    wrapped   = (mid >= LEN_W'(n_q)) ? (mid - LEN_W'(n_q)) : mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      n_q       <= '0;
      idx       <= '0;
      done      <= 1'b0;
      sel_valid <= 1'b0;
      sel_error <= 1'b0;
      tap_out   <= '0;
      for (int k = 0; k < LANES; k++) shift_lane[k] <= '0;
    end else begin
      done      <= 1'b0;
      sel_valid <= 1'b0;
      sel_error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            n_q   <= n_clamp;
            idx   <= '0;
            state <= ST_SCAN;
            for (int k = 0; k < LANES; k++) shift_lane[k] <= folded_lane[k];
          end
        end
        ST_SCAN: begin
          // the scan runs one step past bit 2N-1; the zero fed there closes an open run
          for (int k = 0; k < LANES; k++) shift_lane[k] <= shift_lane[k] >> 1;
          idx <= idx + LEN_W'(1);
          if (idx == last_idx) state <= ST_FINISH;
        end
        ST_FINISH: begin
          done      <= 1'b1;
          sel_valid <= sel_ok;
          sel_error <= !sel_ok;
          tap_out   <= sel_ok ? TAP_W'(wrapped) : '0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: exactly one outcome flag with done
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (sel_valid != sel_error));

  // R9: outcome flags only appear with done
  p_flag_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_valid || sel_error) |-> done);

  // R10: busy only rises after an accepted start
  p_busy_from_start_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R10: a scan in progress is not restarted
  p_scan_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN && idx != last_idx) |=> (state == ST_SCAN));

  // R6: the wrapped midpoint lies inside the tap range
  p_tap_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINISH && sel_ok) |-> (wrapped < LEN_W'(n_q)));

  // R8: a failed selection reports tap 0
  p_error_tap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    sel_error |-> (tap_out == '0));
endmodule

// File: tb/tap_window_picker_tb_top.sv
`timescale 1ns/1ps
module tap_window_picker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  num_taps = '0;
  logic [31:0] pass_vec = '0;
  logic [31:0] match_vec = '0;
  logic        busy, done, sel_valid, sel_error;
  logic [3:0]  tap_out;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  tap_window_picker dut_i (
    .clk(clk), .rst(rst), .start(start), .num_taps(num_taps),
    .pass_vec(pass_vec), .match_vec(match_vec), .busy(busy), .done(done),
    .sel_valid(sel_valid), .sel_error(sel_error), .tap_out(tap_out)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Longest run per R4/R5
  task automatic longest(input logic [31:0] v, input int w,
                         output int cnt, output int s, output int e);
    int ntap = 0;
    cnt = 0; s = 0; e = 0;
    for (int i = 0; i < w; i++) begin
      if (v[i]) ntap++;
      else begin
        if (ntap > cnt) begin s = i - ntap; e = i - 1; cnt = ntap; end
        ntap = 0;
      end
    end
    if (ntap > cnt) begin s = w - ntap; e = w - 1; cnt = ntap; end
  endtask

  // Reference selection per R2..R8, R11
  task automatic model(input int n_in, input logic [31:0] p_in, input logic [31:0] m_in,
                       output bit ok, output int tap);
    int n; int w; int cnt; int s; int e;
    logic [31:0] p; logic [31:0] m;
    n = (n_in > 16) ? 16 : n_in;
    w = 2 * n;
    p = p_in; m = m_in;
    for (int i = 0; i < w; i++) begin
      if (!p[i]) begin p[i % n] = 1'b0; p[(i % n) + n] = 1'b0; end
      if (!m[i]) begin m[i % n] = 1'b0; m[(i % n) + n] = 1'b0; end
    end
    longest(p, w, cnt, s, e);
    if (cnt == w) begin
      longest(m, w, cnt, s, e);
      ok = (cnt != 0);
    end else begin
      ok = (cnt >= 3);
    end
    tap = ok ? ((s + e) / 2) % n : 0;
  endtask

  task automatic run_case(input string req, input int n, input logic [31:0] p,
                          input logic [31:0] m, input bit exp_ok, input int exp_tap);
    int cyc;
    int nc = (n > 16) ? 16 : n;
    @(negedge clk);
    num_taps = 5'(n); pass_vec = p; match_vec = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 100);
    check(cyc == 2 * nc + 2, "R9", {req, " latency"}, cyc, 2 * nc + 2);
    check(sel_valid == exp_ok && sel_error == !exp_ok, req, "valid flag",
          int'(sel_valid), int'(exp_ok));
    if (exp_ok) check(tap_out == 4'(exp_tap), req, "tap", int'(tap_out), exp_tap);
    else check(tap_out == 4'd0, "R8", {req, " error tap"}, int'(tap_out), 0);
    @(negedge clk);
    check(!done && !sel_valid && !sel_error, "R9", "done pulse width", int'(done), 0);
  endtask

  task automatic t_reset;
    check(!done && !sel_valid && !sel_error && !busy, "R1", "flags after reset",
          int'({done, sel_valid, sel_error, busy}), 0);
    check(tap_out == 4'd0, "R1", "tap after reset", int'(tap_out), 0);
  endtask

  task automatic t_fold;
    run_case("R2", 8, 32'h0000_7FFF, 32'h0, 1'b1, 3);        // tap 7 fails second visit
    run_case("R2", 4, 32'h0000_00FF, 32'h0000_00FE, 1'b1, 2); // fold on match vector
    run_case("R2", 8, 32'h0000_6C7C, 32'h0, 1'b0, 0);        // one failing visit splits run
  endtask

  task automatic t_high_bits;
    run_case("R3", 4, 32'h0000_0077, 32'h0, 1'b1, 1);
    run_case("R3", 4, 32'hFFFF_FF77, 32'hFFFF_FF00, 1'b1, 1);
  endtask

  task automatic t_ties;
    run_case("R4", 8, 32'h0000_7777, 32'h0, 1'b1, 1);        // equal runs: earliest
    run_case("R4", 8, 32'h0000_7B7B, 32'h0, 1'b1, 4);        // later strictly longer
  endtask

  task automatic t_threshold;
    run_case("R6", 8, 32'h0000_0C0C, 32'h0, 1'b0, 0);        // length 2
    run_case("R6", 8, 32'h0000_1C1C, 32'h0, 1'b1, 3);        // length 3
    run_case("R6", 8, 32'h0000_8383, 32'h0, 1'b1, 0);        // midpoint wraps mod N
  endtask

  task automatic t_all_pass;
    run_case("R5", 8, 32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 7); // open run at top
    run_case("R7", 8, 32'h0000_FFFF, 32'h0000_0E0E, 1'b1, 2);
    run_case("R7", 8, 32'h0000_FFFF, 32'h0000_8787, 1'b1, 0);
    run_case("R7", 8, 32'h0000_FFFF, 32'h0000_00FF, 1'b0, 0); // no match window
    run_case("R7", 1, 32'h0000_0003, 32'h0000_0003, 1'b1, 0);
    run_case("R7", 1, 32'h0000_0003, 32'h0000_0001, 1'b0, 0);
  endtask

  task automatic t_tap_count;
    run_case("R11", 16, 32'h0FFF_0FFF, 32'h0, 1'b1, 5);
    run_case("R11", 20, 32'h0FFF_0FFF, 32'h0, 1'b1, 5);
    run_case("R11", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0);
  endtask

  task automatic t_busy_start;
    int cyc;
    @(negedge clk);
    num_taps = 5'd8; pass_vec = 32'h0000_7FFF; match_vec = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10", "busy after start", int'(busy), 1);
    cyc = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    num_taps = 5'd4; pass_vec = 32'h0000_0077; start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check(cyc == 18, "R10", "latency with ignored start", cyc, 18);
    check(sel_valid && tap_out == 4'd3, "R10", "result of first start", int'(tap_out), 3);
    @(negedge clk);
    check(!busy, "R10", "idle after done", int'(busy), 0);
  endtask

  task automatic t_sweep;
    logic [31:0] st = 32'h1234_5679;
    logic [31:0] r [4];
    bit ok; int tap; int n;
    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 4; j++) begin
        st ^= st << 13; st ^= st >> 17; st ^= st << 5;
        r[j] = st;
      end
      n = 1 + (k % 16);
      if (k % 3 == 0) r[0] = 32'hFFFF_FFFF;
      model(n, r[0] | r[1], r[2] | r[3], ok, tap);
      run_case("R4", n, r[0] | r[1], r[2] | r[3], ok, tap);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fold();
    t_high_bits();
    t_ties();
    t_threshold();
    t_all_pass();
    t_tap_count();
    t_busy_start();
    t_sweep();
    finish_run();
  end
endmodule